// File: doc/BRIEF.md
# Counter-Pattern Event Checker

This block sits at the receiving end of a data chain whose source runs in counter mode. In that mode every payload word of an event holds the same value, and that value goes up by one from each event to the next. Words arrive on a valid/data stream. A last marker flags the final word of each event, and that word carries a 16-bit CRC computed over the payload.

For every event the checker looks at two things. First, the payload must be uniform and must follow on from the previous event. Second, the CRC recomputed over the received payload must match the trailer. It keeps saturating counts of events seen, pattern failures and CRC failures. A sticky flag rises on any failure and stays up until software pulses a clear input. A resync input drops the expected value, so the next event is taken as a fresh starting point.

Top module: `cpc_event_checker`

## Requirements
- R1: After synchronous reset, all three counters read zero and the sticky error flag is low.
- R2: Each accepted word with `in_last` high ends an event and increments `evt_count` by one, visible on the cycle after it is accepted. Cycles with `in_valid` low have no effect.
- R3: If any payload word differs from the first payload word of its event, the event counts exactly one pattern error.
- R4: The first payload word of an event must equal the previous event's first payload word plus one, modulo 2^16. Otherwise the event counts a pattern error.
- R5: The first event after reset, or after a one-cycle `resync` pulse, is not checked for the increment.
- R6: After every event with at least one payload word, the expected value becomes that event's first payload word plus one, whether or not the event failed.
- R7: The CRC is computed as follows:
  - polynomial 0x1021, initial value 0xFFFF;
  - no input or output reflection and no final XOR;
  - each 16-bit payload word is fed most significant bit first.
  
  The CRC is compared with the trailer word. A mismatch adds one to `crc_err_count`.
- R8: An event made of the trailer alone, with no payload word, counts a pattern error.
- R9: Each counter is CNT_W bits wide (32 by default) and holds at all-ones instead of wrapping.
- R10: `err_flag` rises on the cycle after an event that has any error and stays high until `err_clr`. If `err_clr` arrives in the same cycle as a failing trailer, the flag stays set.
- R11: Pattern and CRC errors are counted independently, so an event with both faults increments both counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Word on `in_data` is valid |
| in_data | input | DATA_W | Payload word or CRC trailer |
| in_last | input | 1 | Marks the trailer word that ends the event |
| resync | input | 1 | Forget the expected value |
| err_clr | input | 1 | Clear the sticky error flag |
| evt_count | output | CNT_W | Events checked, saturating |
| pat_err_count | output | CNT_W | Pattern errors, saturating |
| crc_err_count | output | CNT_W | CRC errors, saturating |
| err_flag | output | 1 | Sticky error flag |

## Verification
A stale expected value shows up as a pattern error on the very next event, one cycle after its trailer. A CRC register that is not re-seeded between events corrupts the comparison of the following event in the same way. The bench sweeps the cases below and compares all four outputs against an arithmetic model one cycle after each trailer:
- payload lengths from zero to four;
- every position of a corrupted payload word;
- both CRC states;
- wrong increments, resyncs and clears.

Saturation is checked at the bench's narrower counter width.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
    localparam int          CRC_W    = 16;
    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_SEED = 16'hFFFF;

    localparam int CNT_EVT = 0;
    localparam int CNT_PAT = 1;
    localparam int CNT_CRC = 2;
    localparam int N_CNT   = 3;

    typedef struct packed {
        logic done;
        logic pat_bad;
        logic crc_bad;
    } evt_result_t;
endpackage

// File: rtl/cpc_crc_acc.sv
module cpc_crc_acc
    import cpc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_vld,
    input  logic              word_last,
    input  logic [DATA_W-1:0] word,
    output logic              crc_bad
);
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_nxt;

    always_comb begin
        crc_nxt = crc_q;
        for (int b = DATA_W - 1; b >= 0; b--) begin
            crc_nxt = {crc_nxt[CRC_W-2:0], 1'b0}
                    ^ ({CRC_W{crc_nxt[CRC_W-1] ^ word[b]}} & CRC_POLY);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= CRC_SEED;
        end else if (word_vld) begin
            crc_q <= word_last ? CRC_SEED : crc_nxt;
        end
    end

    assign crc_bad = word_vld && word_last && (crc_q != word[CRC_W-1:0]);

    // R7: register is re-seeded for the next event after every trailer
    p_crc_reseed_r7: assert property (@(posedge clk) disable iff (rst)
        (word_vld && word_last) |=> (crc_q == CRC_SEED));
endmodule

// File: rtl/cpc_pattern_chk.sv
module cpc_pattern_chk #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              resync,
    input  logic              word_vld,
    input  logic              word_last,
    input  logic [DATA_W-1:0] word,
    output logic              pat_bad
);
    logic              have_first_q;
    logic              mismatch_q;
    logic [DATA_W-1:0] first_q;
    logic [DATA_W-1:0] expect_q;
    logic              expect_vld_q;
    logic              evt_end;

    assign evt_end = word_vld && word_last;
    assign pat_bad = evt_end &&
                     (!have_first_q || mismatch_q ||
                      (expect_vld_q && (first_q != expect_q)));

    always_ff @(posedge clk) begin
        if (rst) begin
            have_first_q <= 1'b0;
            mismatch_q   <= 1'b0;
            first_q      <= '0;
            expect_q     <= '0;
            expect_vld_q <= 1'b0;
        end else begin
            if (evt_end) begin
                have_first_q <= 1'b0;
                mismatch_q   <= 1'b0;
                if (have_first_q) begin
                    expect_q     <= first_q + 1'b1;
                    expect_vld_q <= 1'b1;
                end
            end else if (word_vld) begin
                if (!have_first_q) begin
                    first_q      <= word;
                    have_first_q <= 1'b1;
                end else if (word != first_q) begin
                    mismatch_q <= 1'b1;
                end
            end
            if (resync) begin
                expect_vld_q <= 1'b0;
            end
        end
    end

    // R5: a resync pulse leaves no expectation behind
    p_resync_drops_r5: assert property (@(posedge clk) disable iff (rst)
        resync |=> !expect_vld_q);
    // R8: a trailer with no payload always reports a pattern error
    p_empty_bad_r8: assert property (@(posedge clk) disable iff (rst)
        (evt_end && !have_first_q) |-> pat_bad);
endmodule

// File: rtl/cpc_sat_cnt.sv
module cpc_sat_cnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt = cnt_q;

    // R9: a full counter never wraps
    p_sat_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
    // R2: without an increment the count does not move
    p_idle_stable_r2: assert property (@(posedge clk) disable iff (rst)
        !inc |=> $stable(cnt_q));
endmodule

// File: rtl/cpc_event_checker.sv
module cpc_event_checker
    import cpc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    input  logic              resync,
    input  logic              err_clr,
    output logic [CNT_W-1:0]  evt_count,
    output logic [CNT_W-1:0]  pat_err_count,
    output logic [CNT_W-1:0]  crc_err_count,
    output logic              err_flag
);
    evt_result_t      res;
    logic [N_CNT-1:0] cnt_inc;
    logic [CNT_W-1:0] cnt_val [N_CNT];
    logic             err_q;

    assign res.done = in_valid && in_last;

    cpc_pattern_chk #(.DATA_W(DATA_W)) pat_i (
        .clk       (clk),
        .rst       (rst),
        .resync    (resync),
        .word_vld  (in_valid),
        .word_last (in_last),
        .word      (in_data),
        .pat_bad   (res.pat_bad)
    );

    cpc_crc_acc #(.DATA_W(DATA_W)) crc_i (
        .clk       (clk),
        .rst       (rst),
        .word_vld  (in_valid),
        .word_last (in_last),
        .word      (in_data),
        .crc_bad   (res.crc_bad)
    );

    assign cnt_inc[CNT_EVT] = res.done;
    assign cnt_inc[CNT_PAT] = res.pat_bad;
    assign cnt_inc[CNT_CRC] = res.crc_bad;

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        cpc_sat_cnt #(.CNT_W(CNT_W)) cnt_i (
            .clk (clk),
            .rst (rst),
            .inc (cnt_inc[g]),
            .cnt (cnt_val[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else if (res.pat_bad || res.crc_bad) begin
            err_q <= 1'b1;
        end else if (err_clr) begin
            err_q <= 1'b0;
        end
    end

    assign evt_count     = cnt_val[CNT_EVT];
    assign pat_err_count = cnt_val[CNT_PAT];
    assign crc_err_count = cnt_val[CNT_CRC];
    assign err_flag      = err_q;

    // R10: the flag holds until an explicit clear
    p_sticky_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (err_q && !err_clr) |=> err_q);
    // R10: a failing event always leaves the flag set
    p_err_sets_r10: assert property (@(posedge clk) disable iff (rst)
        (res.pat_bad || res.crc_bad) |=> err_q);
    // R3: errors are only reported on an event's trailer
    p_err_on_end_r3: assert property (@(posedge clk) disable iff (rst)
        (res.pat_bad || res.crc_bad) |-> res.done);
endmodule

// File: tb/cpc_event_checker_tb.sv
module cpc_event_checker_tb_top;
    localparam int DW = 16;
    localparam int CW = 8;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [DW-1:0] in_data;
    logic          in_last;
    logic          resync;
    logic          err_clr;
    logic [CW-1:0] evt_count;
    logic [CW-1:0] pat_err_count;
    logic [CW-1:0] crc_err_count;
    logic          err_flag;

    int n_checks = 0;
    int n_fail   = 0;

    int          m_evt = 0;
    int          m_pat = 0;
    int          m_crc = 0;
    bit          m_flag = 0;
    bit          m_vld = 0;
    logic [15:0] m_exp = '0;

    always #5 clk = ~clk;

    cpc_event_checker #(.DATA_W(DW), .CNT_W(CW)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .in_valid      (in_valid),
        .in_data       (in_data),
        .in_last       (in_last),
        .resync        (resync),
        .err_clr       (err_clr),
        .evt_count     (evt_count),
        .pat_err_count (pat_err_count),
        .crc_err_count (crc_err_count),
        .err_flag      (err_flag)
    );

    function automatic logic [15:0] crc_word(input logic [15:0] c, input logic [15:0] w);
        logic [15:0] r = c;
        for (int b = 15; b >= 0; b--) begin
            if (r[15] ^ w[b]) r = (r << 1) ^ 16'h1021;
            else              r = r << 1;
        end
        return r;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        return (v > CMAX) ? CMAX : v;
    endfunction

    task automatic check_all(input string tag);
        check({tag, " evt_count"}, int'(evt_count), sat(m_evt));
        check({tag, " pat_err_count"}, int'(pat_err_count), sat(m_pat));
        check({tag, " crc_err_count"}, int'(crc_err_count), sat(m_crc));
        check({tag, " err_flag"}, int'(err_flag), int'(m_flag));
    endtask

    // n payload words equal to base; word bad_idx (1..n-1) flipped; optional idle gaps
    task automatic send_evt(input logic [15:0] base, input int n, input int bad_idx,
                            input bit crc_fault, input bit gaps, input bit clr_at_end,
                            input string tag);
        logic [15:0] c = 16'hFFFF;
        bit pbad;
        for (int i = 0; i < n; i++) begin
            logic [15:0] w = (i == bad_idx) ? (base ^ 16'h0100) : base;
            in_valid = 1'b1; in_data = w; in_last = 1'b0;
            c = crc_word(c, w);
            @(negedge clk);
            if (gaps) begin
                in_valid = 1'b0; in_data = 16'hDEAD;
                @(negedge clk);
            end
        end
        in_valid = 1'b1; in_last = 1'b1;
        in_data  = crc_fault ? (c ^ 16'h0001) : c;
        err_clr  = clr_at_end;
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; err_clr = 1'b0;
        pbad = (n == 0) || (bad_idx > 0 && bad_idx < n) || (m_vld && n > 0 && base != m_exp);
        m_evt++;
        if (pbad) m_pat++;
        if (crc_fault) m_crc++;
        if (pbad || crc_fault) m_flag = 1;
        if (n > 0) begin m_exp = base + 16'd1; m_vld = 1; end
        check_all(tag);
    endtask

    initial begin
        rst = 1'b1; in_valid = 0; in_data = '0; in_last = 0; resync = 0; err_clr = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R1 reset");

        // idle cycles with junk data but valid low
        in_data = 16'h5555; in_last = 1'b1;
        repeat (3) @(negedge clk);
        in_last = 1'b0;
        check_all("R2 idle");

        send_evt(16'd100, 3, -1, 0, 0, 0, "R5 first event after reset");

        for (int n = 1; n <= 4; n++)
            for (int bad = 0; bad < n; bad++)
                for (int cf = 0; cf < 2; cf++)
                    send_evt(m_exp, n, (bad == 0) ? -1 : bad, cf[0], n[0], 0,
                             "R3 R7 R11 sweep");

        send_evt(m_exp + 16'd5, 2, -1, 0, 0, 0, "R4 wrong increment");
        send_evt(m_exp, 2, -1, 0, 0, 0, "R6 follows received value");

        m_exp = 16'hFFFF;
        send_evt(16'hFFFE, 1, -1, 0, 0, 0, "R4 setup wrap");
        send_evt(16'hFFFF, 1, -1, 0, 1, 0, "R4 before wrap");
        send_evt(16'h0000, 2, -1, 0, 0, 0, "R4 wrap to zero");

        resync = 1'b1; @(negedge clk); resync = 1'b0;
        m_vld = 0;
        check_all("R5 resync no event");
        send_evt(16'd9000, 2, -1, 0, 0, 0, "R5 after resync");

        send_evt(16'd0, 0, -1, 0, 0, 0, "R8 empty event");
        send_evt(m_exp, 2, -1, 0, 0, 0, "R8 expectation kept");

        err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
        m_flag = 0;
        check_all("R10 clear");
        send_evt(m_exp, 1, -1, 0, 0, 1, "R10 clear with good event");
        send_evt(m_exp, 2, -1, 1, 0, 1, "R10 clear loses to error");

        for (int i = 0; i < 260; i++) begin
            bit last_one = (i == 259);
            send_evt(m_exp, 1, -1, last_one, 0, 0, "R9 saturation");
        end
        check("R9 evt_count held at max", int'(evt_count), CMAX);

        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    end
endmodule